// File: doc/BRIEF.md
# DDR Read Capture Latency Aligner

This block sits between the read side of a DDR memory PHY and an on-chip read data channel. Each time the controller issues a READ, the block notes the configured read latency and the fetch margin. The fetch margin absorbs board delay, PHY input and output delay and strobe-to-clock skew. The block counts down the sum of the two and, on the right clock edge, pops the captured beat pair from the PHY input buffer. It packs the pair into one double-width word and queues the word for a valid/ready consumer.

The fetch margin is normally set from the path delay as ceil(delay/T + 0.75), and it is never less than one cycle. Up to four READs may be pending at once. Each READ keeps the latency settings that were present when it was taken. Words leave in the order the READs were issued. A burst is 4 or 8 DDR beats, which gives 2 or 4 output words. A small output FIFO absorbs back-pressure, and any word lost to a full FIFO sets a sticky error flag.

Top module: `rdcap_align`

## Requirements
- R1: While `rst` is high on a clock edge, the block drops all pending READs and empties the FIFO. After such an edge, `rd_valid`, `phy_pop` and `err_ovf` read 0.
- R2: Suppose a READ is taken on clock edge k with read latency RL and fetch margin F ≥ 1. Then `phy_pop` is high in the cycle before edge k+RL+F, the beat pair is captured on edge k+RL+F, and the first word is valid right after that edge. For example, RL=3 with F=1 gives 4 cycles, and RL=3 with F=2 gives 5 cycles.
- R3: A fetch margin of 0 is treated as 1. So RL=3 with F=0 gives 4 cycles, and RL=0 with F=0 gives 1 cycle.
- R4: Each output word is {`phy_fall`, `phy_rise`} as captured at the fetch edge. The later beat is in bits [2*BEAT_W-1:BEAT_W] and the earlier beat is in bits [BEAT_W-1:0].
- R5: With `cfg_bl8`=0 a READ yields 2 words, and with `cfg_bl8`=1 it yields 4. The words come on consecutive cycles, and `rd_last` is high on the final word only.
- R6: RL, F and burst length are sampled on the edge that takes the READ. Changing them afterwards has no effect on that READ.
- R7: Words leave in READ issue order. A READ whose countdown expires while an older burst is still pending waits until that burst is done.
- R8: While `rd_valid` is high and `rd_ready` is low, `rd_data` and `rd_last` hold steady. Up to FIFO_DEPTH (4) words are kept without loss.
- R9: A word produced while the FIFO is full and not being read is dropped and sets `err_ovf`. `err_ovf` stays high until reset.
- R10: A READ that arrives while QDEPTH (4) READs are pending is ignored and produces no words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_rd | input | 1 | READ issued on this edge |
| cfg_rl | input | CFG_W (3) | Read latency in cycles |
| cfg_fetch | input | CFG_W (3) | Fetch margin in cycles, 0 treated as 1 |
| cfg_bl8 | input | 1 | 1 selects an 8-beat burst, 0 selects a 4-beat burst |
| phy_rise | input | BEAT_W (16) | Earlier captured beat at the head of the PHY buffer |
| phy_fall | input | BEAT_W (16) | Later captured beat at the head of the PHY buffer |
| phy_pop | output | 1 | Head beat pair is consumed on the next edge |
| rd_valid | output | 1 | Output word available |
| rd_ready | input | 1 | Consumer accepts the word |
| rd_data | output | 2*BEAT_W (32) | Packed word |
| rd_last | output | 1 | Final word of a burst |
| err_ovf | output | 1 | Sticky FIFO overflow flag |

## Verification
Single READs are issued over a spread of latency and margin pairs, including a zero margin and a zero latency. These separate a correct RL+F count from off-by-one errors and from a missing clamp. In one test the configuration is changed right after a READ is taken, which shows whether the settings are latched per command. A long READ followed by a short one exposes any reordering, because the position of the first `rd_last` tells the two apart. Back-to-back READs beyond the queue depth, a stalled consumer, and a forced overflow cover the hold, drop and sticky-flag behaviour. The PHY model increments the beat values on every pop, so the word data also shows the beat order and whether any word was skipped.

// File: rtl/rdcap_pkg.sv
package rdcap_pkg;

   typedef enum logic {
      BURST_4 = 1'b0,
      BURST_8 = 1'b1
   } burst_e;

   // Output words per burst: each word carries two DDR beats.
   function automatic int unsigned burst_words(burst_e b);
      return (b == BURST_8) ? 4 : 2;
   endfunction

endpackage

// File: rtl/rdcap_cmd_queue.sv
module rdcap_cmd_queue
   import rdcap_pkg::*;
#(
   parameter int CFG_W  = 3,
   parameter int QDEPTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cmd_rd,
   input  logic [CFG_W-1:0] cfg_rl,
   input  logic [CFG_W-1:0] cfg_fetch,
   input  logic             cfg_bl8,
   output logic             fetch,
   output logic             fetch_last,
   output logic             cmd_taken
);
   localparam int CNT_W = CFG_W + 1;
   localparam int QP_W  = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
   localparam int OCC_W = $clog2(QDEPTH + 1);
   localparam int WRD_W = 3;

   logic [CFG_W-1:0] fetch_eff;
   logic [CNT_W-1:0] lat_load;
   logic [WRD_W-1:0] burst_len;
   logic [QP_W-1:0]  hp, tp;
   logic [OCC_W-1:0] occ;
   logic             q_full;

   logic             s_vld [QDEPTH];
   logic [CNT_W-1:0] s_cnt [QDEPTH];
   logic [WRD_W-1:0] s_wrd [QDEPTH];

   // Margin of zero is clamped to one; counter loads total minus one so
   // that the head reaches zero in the cycle before the capture edge.
   always_comb begin
      fetch_eff = (cfg_fetch == '0) ? CFG_W'(1) : cfg_fetch;
      lat_load  = CNT_W'(cfg_rl) + CNT_W'(fetch_eff) - CNT_W'(1);
      burst_len = WRD_W'(burst_words(burst_e'(cfg_bl8)));
   end

   assign q_full     = (occ == OCC_W'(QDEPTH));
   assign cmd_taken  = cmd_rd && !q_full;
   assign fetch      = s_vld[hp] && (s_cnt[hp] == '0);
   assign fetch_last = fetch && (s_wrd[hp] == WRD_W'(1));

   for (genvar i = 0; i < QDEPTH; i++) begin : g_slot
      logic             vld_q;
      logic [CNT_W-1:0] cnt_q;
      logic [WRD_W-1:0] wrd_q;
      logic             load_me, head_me;

      assign load_me = cmd_taken && (tp == QP_W'(i));
      assign head_me = fetch && (hp == QP_W'(i));

      always_ff @(posedge clk) begin
         if (rst) begin
            vld_q <= 1'b0;
            cnt_q <= '0;
            wrd_q <= '0;
         end else if (load_me) begin
            vld_q <= 1'b1;
            cnt_q <= lat_load;
            wrd_q <= burst_len;
         end else begin
            if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
            if (head_me) begin
               wrd_q <= wrd_q - WRD_W'(1);
               if (wrd_q == WRD_W'(1)) vld_q <= 1'b0;
            end
         end
      end

      assign s_vld[i] = vld_q;
      assign s_cnt[i] = cnt_q;
      assign s_wrd[i] = wrd_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hp  <= '0;
         tp  <= '0;
         occ <= '0;
      end else begin
         if (cmd_taken)  tp <= tp + QP_W'(1);
         if (fetch_last) hp <= hp + QP_W'(1);
         case ({cmd_taken, fetch_last})
            2'b10:   occ <= occ + OCC_W'(1);
            2'b01:   occ <= occ - OCC_W'(1);
            default: occ <= occ;
         endcase
      end
   end

endmodule

// File: rtl/rdcap_beat_pack.sv
module rdcap_beat_pack #(
   parameter int BEAT_W   = 16,
   parameter bit PACK_REG = 1'b0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_vld,
   input  logic                in_last,
   input  logic [BEAT_W-1:0]   rise,
   input  logic [BEAT_W-1:0]   fall,
   output logic                out_vld,
   output logic                out_last,
   output logic [2*BEAT_W-1:0] out_word
);
   // Earlier beat goes to the low half, later beat to the high half.
   logic [2*BEAT_W-1:0] joined;
   assign joined = {fall, rise};

   if (PACK_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            out_vld  <= 1'b0;
            out_last <= 1'b0;
            out_word <= '0;
         end else begin
            out_vld  <= in_vld;
            out_last <= in_vld && in_last;
            out_word <= joined;
         end
      end
   end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst;
      assign out_vld  = in_vld;
      assign out_last = in_vld && in_last;
      assign out_word = joined;
   end

endmodule

// File: rtl/rdcap_out_fifo.sv
module rdcap_out_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         wr,
   input  logic [W-1:0] wr_data,
   input  logic         wr_last,
   input  logic         rd_ready,
   output logic         rd_valid,
   output logic [W-1:0] rd_data,
   output logic         rd_last,
   output logic         full,
   output logic         ovf
);
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int OCC_W = $clog2(DEPTH + 1);

   logic [W:0]       mem [DEPTH];
   logic [AW-1:0]    wp, rp;
   logic [OCC_W-1:0] occ;
   logic             rd_fire, wr_ok;

   assign rd_valid = (occ != '0);
   assign full     = (occ == OCC_W'(DEPTH));
   assign rd_fire  = rd_valid && rd_ready;
   assign wr_ok    = wr && (!full || rd_fire);
   assign ovf      = wr && full && !rd_fire;
   assign rd_data  = rd_valid ? mem[rp][W-1:0] : '0;
   assign rd_last  = rd_valid && mem[rp][W];

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wp] <= {wr_last, wr_data};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wp  <= '0;
         rp  <= '0;
         occ <= '0;
      end else begin
         if (wr_ok)   wp <= wp + AW'(1);
         if (rd_fire) rp <= rp + AW'(1);
         case ({wr_ok, rd_fire})
            2'b10:   occ <= occ + OCC_W'(1);
            2'b01:   occ <= occ - OCC_W'(1);
            default: occ <= occ;
         endcase
      end
   end

endmodule

// File: rtl/rdcap_align.sv
module rdcap_align #(
   parameter int BEAT_W     = 16,
   parameter int CFG_W      = 3,
   parameter int QDEPTH     = 4,
   parameter int FIFO_DEPTH = 4,
   parameter bit PACK_REG   = 1'b0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                cmd_rd,
   input  logic [CFG_W-1:0]    cfg_rl,
   input  logic [CFG_W-1:0]    cfg_fetch,
   input  logic                cfg_bl8,
   input  logic [BEAT_W-1:0]   phy_rise,
   input  logic [BEAT_W-1:0]   phy_fall,
   output logic                phy_pop,
   output logic                rd_valid,
   input  logic                rd_ready,
   output logic [2*BEAT_W-1:0] rd_data,
   output logic                rd_last,
   output logic                err_ovf
);
   localparam int WORD_W = 2 * BEAT_W;

   if (BEAT_W < 1) begin : g_bad_beat
      $error("BEAT_W must be at least 1");
   end
   if (CFG_W < 1 || CFG_W > 6) begin : g_bad_cfg
      $error("CFG_W must lie in 1..6");
   end
   if (QDEPTH < 2 || (QDEPTH & (QDEPTH - 1)) != 0) begin : g_bad_q
      $error("QDEPTH must be a power of two, at least 2");
   end
   if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_f
      $error("FIFO_DEPTH must be a power of two, at least 2");
   end

   logic              fetch, fetch_last, cmd_taken;
   logic              pk_vld, pk_last;
   logic [WORD_W-1:0] pk_word;
   logic              fifo_full, fifo_ovf;

   rdcap_cmd_queue #(.CFG_W(CFG_W), .QDEPTH(QDEPTH)) u_queue (
      .clk        (clk),
      .rst        (rst),
      .cmd_rd     (cmd_rd),
      .cfg_rl     (cfg_rl),
      .cfg_fetch  (cfg_fetch),
      .cfg_bl8    (cfg_bl8),
      .fetch      (fetch),
      .fetch_last (fetch_last),
      .cmd_taken  (cmd_taken)
   );

   assign phy_pop = fetch;

   rdcap_beat_pack #(.BEAT_W(BEAT_W), .PACK_REG(PACK_REG)) u_pack (
      .clk      (clk),
      .rst      (rst),
      .in_vld   (fetch),
      .in_last  (fetch_last),
      .rise     (phy_rise),
      .fall     (phy_fall),
      .out_vld  (pk_vld),
      .out_last (pk_last),
      .out_word (pk_word)
   );

   rdcap_out_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk      (clk),
      .rst      (rst),
      .wr       (pk_vld),
      .wr_data  (pk_word),
      .wr_last  (pk_last),
      .rd_ready (rd_ready),
      .rd_valid (rd_valid),
      .rd_data  (rd_data),
      .rd_last  (rd_last),
      .full     (fifo_full),
      .ovf      (fifo_ovf)
   );

   always_ff @(posedge clk) begin
      if (rst)           err_ovf <= 1'b0;
      else if (fifo_ovf) err_ovf <= 1'b1;
   end

endmodule

// File: rtl/rdcap_align_chk.sv
module rdcap_align_chk #(
   parameter int QDEPTH = 4,
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              cmd_taken,
   input logic              phy_pop,
   input logic              fetch_last,
   input logic              pk_vld,
   input logic              fifo_full,
   input logic              rd_valid,
   input logic              rd_ready,
   input logic [WORD_W-1:0] rd_data,
   input logic              rd_last,
   input logic              err_ovf
);
   logic [7:0] pend;
   logic       rst_d;

   always_ff @(posedge clk) begin
      rst_d <= rst;
      if (rst) pend <= '0;
      else     pend <= pend + 8'(cmd_taken) - 8'(phy_pop && fetch_last);
   end

   // R1: outputs cleared after a reset edge
   always @(posedge clk) begin
      if (rst_d === 1'b1) begin
         p_reset_clear_r1: assert (!rd_valid && !phy_pop && !err_ovf)
            else $error("outputs not cleared after reset");
      end
   end

   p_pop_pending_r7: assert property (@(posedge clk) disable iff (rst)
      phy_pop |-> (pend != 8'd0));

   p_queue_depth_r10: assert property (@(posedge clk) disable iff (rst)
      pend <= 8'(QDEPTH));

   p_hold_stall_r8: assert property (@(posedge clk) disable iff (rst)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_last)));

   p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      err_ovf |=> err_ovf);

   p_err_cause_r9: assert property (@(posedge clk) disable iff (rst)
      $rose(err_ovf) |-> $past(pk_vld && fifo_full && !(rd_valid && rd_ready)));

endmodule

bind rdcap_align rdcap_align_chk #(.QDEPTH(QDEPTH), .WORD_W(2 * BEAT_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .cmd_taken  (cmd_taken),
   .phy_pop    (phy_pop),
   .fetch_last (fetch_last),
   .pk_vld     (pk_vld),
   .fifo_full  (fifo_full),
   .rd_valid   (rd_valid),
   .rd_ready   (rd_ready),
   .rd_data    (rd_data),
   .rd_last    (rd_last),
   .err_ovf    (err_ovf)
);

// File: tb/tb_rdcap_align.sv
`timescale 1ns/1ps
module tb_rdcap_align;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cmd_rd = 1'b0;
   logic [2:0]  cfg_rl = 3'd0;
   logic [2:0]  cfg_fetch = 3'd0;
   logic        cfg_bl8 = 1'b0;
   logic [15:0] phy_rise = 16'h0;
   logic [15:0] phy_fall = 16'h0;
   logic        phy_pop;
   logic        rd_valid;
   logic        rd_ready = 1'b1;
   logic [31:0] rd_data;
   logic        rd_last;
   logic        err_ovf;

   int  checks = 0;
   int  fails  = 0;
   bit  mon_en = 1'b0;
   bit  done   = 1'b0;
   int  pop_idx = 0;
   bit  pop_pend = 1'b0;
   int  exp_idx = 0;

   always #4 clk = ~clk;

   rdcap_align dut (
      .clk(clk), .rst(rst), .cmd_rd(cmd_rd), .cfg_rl(cfg_rl), .cfg_fetch(cfg_fetch),
      .cfg_bl8(cfg_bl8), .phy_rise(phy_rise), .phy_fall(phy_fall), .phy_pop(phy_pop),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last),
      .err_ovf(err_ovf)
   );

   function automatic logic [31:0] word_of(int n);
      return {16'(32'hA000 + 2*n + 1), 16'(32'hA000 + 2*n)};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // PHY model: the beat pair advances after every edge that pops it.
   always @(negedge clk) begin
      if (rst) begin
         pop_idx  = 0;
         pop_pend = 1'b0;
      end else begin
         if (pop_pend) pop_idx++;
         pop_pend = phy_pop;
      end
      phy_rise = 16'(32'hA000 + 2*pop_idx);
      phy_fall = 16'(32'hA000 + 2*pop_idx + 1);
   end

   // R4: every accepted word is the next beat pair, later beat high.
   always @(negedge clk) begin
      if (rst) exp_idx = 0;
      else if (mon_en && rd_valid && rd_ready) begin
         chk(rd_data == word_of(exp_idx), "R4", "packed word", rd_data, word_of(exp_idx));
         exp_idx++;
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      step();
      rst = 1'b1; cmd_rd = 1'b0; rd_ready = 1'b1;
      repeat (3) step();
      rst = 1'b0;
      mon_en = 1'b1;
   endtask

   task automatic issue(input int rl, input int f, input bit bl8);
      step();
      cmd_rd = 1'b1; cfg_rl = 3'(rl); cfg_fetch = 3'(f); cfg_bl8 = bl8;
      step();
      cmd_rd = 1'b0;
   endtask

   task automatic measure(output int m);
      m = 0;
      forever begin
         @(negedge clk);
         if (rd_valid || m > 40) break;
         m++;
      end
   endtask

   task automatic drain(input int cycles, output int words, output int lasts,
                        output int first_last);
      words = 0; lasts = 0; first_last = 0;
      for (int c = 0; c < cycles; c++) begin
         if (rd_valid && rd_ready) begin
            words++;
            if (rd_last) begin
               lasts++;
               if (first_last == 0) first_last = words;
            end
         end
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      do_reset();
      @(negedge clk);
      chk(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);
      chk(phy_pop == 1'b0, "R1", "phy_pop after reset", phy_pop, 0);
      chk(err_ovf == 1'b0, "R1", "err_ovf after reset", err_ovf, 0);
   endtask

   task automatic t_latency(input int rl, input int f, input bit bl8,
                            input int exp_lat, input string req);
      int m, w, l, fl;
      issue(rl, f, bl8);
      measure(m);
      chk(m == exp_lat, req, "fetch latency", m, exp_lat);
      drain(12, w, l, fl);
      chk(w == (bl8 ? 4 : 2), "R5", "words per burst", w, bl8 ? 4 : 2);
      chk(l == 1, "R5", "last count", l, 1);
      chk(fl == w, "R5", "last position", fl, w);
   endtask

   task automatic t_cfg_change();
      int m, w, l, fl;
      step();
      cmd_rd = 1'b1; cfg_rl = 3'd2; cfg_fetch = 3'd1; cfg_bl8 = 1'b0;
      step();
      cmd_rd = 1'b0; cfg_rl = 3'd7; cfg_fetch = 3'd7; cfg_bl8 = 1'b1;
      measure(m);
      chk(m == 3, "R6", "latency kept after cfg change", m, 3);
      drain(12, w, l, fl);
      chk(w == 2, "R6", "burst kept after cfg change", w, 2);
   endtask

   task automatic t_order();
      int w, l, fl;
      step();
      cmd_rd = 1'b1; cfg_rl = 3'd7; cfg_fetch = 3'd3; cfg_bl8 = 1'b1;
      step();
      cfg_rl = 3'd1; cfg_fetch = 3'd2; cfg_bl8 = 1'b0;
      step();
      cmd_rd = 1'b0;
      @(negedge clk);
      drain(30, w, l, fl);
      chk(w == 6, "R7", "words from long+short", w, 6);
      chk(fl == 4, "R7", "long burst ends first", fl, 4);
      chk(l == 2, "R7", "last count", l, 2);
   endtask

   task automatic t_queue_full();
      int w, l, fl;
      step();
      cmd_rd = 1'b1; cfg_rl = 3'd7; cfg_fetch = 3'd7; cfg_bl8 = 1'b0;
      repeat (5) step();
      cmd_rd = 1'b0;
      @(negedge clk);
      drain(40, w, l, fl);
      chk(w == 8, "R10", "words with fifth READ ignored", w, 8);
      chk(l == 4, "R10", "bursts with fifth READ ignored", l, 4);
   endtask

   task automatic t_backpressure();
      int w, l, fl;
      step();
      rd_ready = 1'b0;
      issue(2, 2, 1'b1);
      repeat (12) @(negedge clk);
      chk(rd_valid == 1'b1, "R8", "valid held while stalled", rd_valid, 1);
      chk(rd_data == word_of(exp_idx), "R8", "head word held", rd_data, word_of(exp_idx));
      chk(err_ovf == 1'b0, "R8", "no overflow at depth 4", err_ovf, 0);
      step();
      rd_ready = 1'b1;
      @(negedge clk);
      drain(10, w, l, fl);
      chk(w == 4, "R8", "all held words delivered", w, 4);
      chk(fl == 4, "R8", "last on fourth word", fl, 4);
   endtask

   task automatic t_overflow();
      int w, l, fl;
      mon_en = 1'b0;
      step();
      rd_ready = 1'b0;
      issue(1, 1, 1'b1);
      repeat (5) step();
      issue(1, 1, 1'b0);
      repeat (10) @(negedge clk);
      chk(err_ovf == 1'b1, "R9", "overflow flagged", err_ovf, 1);
      step();
      rd_ready = 1'b1;
      @(negedge clk);
      drain(10, w, l, fl);
      chk(w == 4, "R9", "only FIFO depth kept", w, 4);
      chk(err_ovf == 1'b1, "R9", "flag sticky after drain", err_ovf, 1);
      do_reset();
      @(negedge clk);
      chk(err_ovf == 1'b0, "R9", "flag cleared by reset", err_ovf, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_latency(3, 1, 1'b0, 4, "R2");
      t_latency(3, 2, 1'b0, 5, "R2");
      t_latency(5, 7, 1'b1, 12, "R2");
      t_latency(3, 0, 1'b0, 4, "R3");
      t_latency(0, 0, 1'b1, 1, "R3");
      t_latency(2, 3, 1'b1, 5, "R5");
      t_cfg_change();
      t_order();
      t_queue_full();
      t_backpressure();
      t_overflow();
      t_latency(4, 1, 1'b0, 5, "R2");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule